// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This block is a memory-mapped real-time counter. A 47-bit count advances once per slow-clock tick, which arrives as a one-cycle enable pulse on the fast system clock. The upper 32 bits of the count hold whole seconds and the lower 15 bits hold the fraction of a second. A 32-bit alarm value is compared with the seconds field. On a match, a sticky flag is raised. That flag drives an interrupt output and, when allowed, a wakeup output.

Software uses a simple 32-bit register bus. Writes take effect on the next clock edge, and reads are combinational. The run, alarm-enable and wakeup-enable controls are first held in a shadow register. They reach the counting logic only after passing through a pipeline that advances on slow ticks. Reading the control register returns this synchronized state, so software polls it to learn when a change has landed. The count can be loaded only while counting is stopped. Reading the count twice in a row and getting the same value gives a coherent reading. A guard register holds a fixed pattern that marks the unit as initialized.

Top module: `lp_rtc`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero, and `irqOut`, `wakeOut` and `glitchOk` are low.
- R2: The control register (offset 0x04) has run at bit 0, alarm enable at bit 1 and wakeup enable at bit 3. A written value reaches the readback and the logic on the third slow tick after the write. Until then the old value reads back. All other control bits read zero.
- R3: While run is in effect, the count grows by exactly one on each slow tick. While run is off, the count holds.
- R4: While run is off, a write to count-low (0x20) loads count bits [31:15] from data bits [31:15] and clears bits [14:0]. A write to count-high (0x1C) loads count bits [46:32] from data bits [14:0]. Count-high reads count bits [46:32], zero-extended.
- R5: While run is in effect, writes to count-low and count-high are ignored.
- R6: The alarm register (0x24) holds 32 bits. When alarm enable is in effect and the seconds field (count bits [46:15]) equals it, status bit 0 (0x18) is set by the next clock edge.
- R7: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. If the match condition holds in the same cycle, the set wins.
- R8: `irqOut` is the status flag gated by the synchronized alarm enable. `wakeOut` also requires the synchronized wakeup enable.
- R9: The guard register (0x30) reads back what was written. `glitchOk` is high exactly when it holds 0x41736166.
- R10: Unmapped offsets (for example 0x08) read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| slowTick | input | 1 | One-cycle pulse per slow-clock period |
| busSel | input | 1 | Register access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid during a read request |
| irqOut | output | 1 | Alarm interrupt |
| wakeOut | output | 1 | Wakeup request |
| glitchOk | output | 1 | Guard register holds the expected pattern |

## Verification
A corrupted sync stage shows up at the control readback and at the count's behaviour within three slow ticks of a control write. The bench polls at every tick of that window. A wrong count or a missed load appears at the next read of count-low or count-high. A fault in the flag or its gating shows on `irqOut`, `wakeOut` and status bit 0 one clock after the seconds field meets the alarm value. The checker watches the count, the synchronized controls and the flag on every cycle, so a divergence is reported on the cycle it occurs.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 47;
  localparam int SUB_W  = 15;
  localparam int SEC_W  = CNT_W - SUB_W;
  localparam int HI_W   = CNT_W - DATA_W;
  localparam int CTRL_W = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CNTHI  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CNTLO  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ALARM  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_GUARD  = 8'h30;

  localparam int BIT_RUN  = 0;
  localparam int BIT_ALM  = 1;
  localparam int BIT_WAKE = 3;

  localparam logic [DATA_W-1:0] GUARD_MAGIC = 32'h4173_6166;

  typedef struct packed {
    logic ctrlWr;
    logic statusWr;
    logic cntLoWr;
    logic cntHiWr;
    logic alarmWr;
    logic guardWr;
  } regStrobe_t;

  typedef struct packed {
    logic wake;
    logic alm;
    logic run;
  } ctrlBits_t;
endpackage

// File: rtl/lp_rtc_ctrl.sv
module lp_rtc_ctrl
  import lp_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slowTick,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output regStrobe_t        strb,
  output ctrlBits_t         ctrlSync,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [DATA_W-1:0] alarmVal,
  input  logic              alarmFlag,
  input  logic [DATA_W-1:0] guardVal
);
  localparam int LAST = SYNC_STAGES - 1;

  ctrlBits_t shadow;
  ctrlBits_t stage [SYNC_STAGES];
  logic wrReq;
  logic rdReq;
  logic [DATA_W-1:0] rdMux;

  assign wrReq = busSel && busWr;
  assign rdReq = busSel && !busWr;

  always_comb begin
    strb          = '0;
    strb.ctrlWr   = wrReq && (busAddr == OFS_CTRL);
    strb.statusWr = wrReq && (busAddr == OFS_STATUS);
    strb.cntLoWr  = wrReq && (busAddr == OFS_CNTLO);
    strb.cntHiWr  = wrReq && (busAddr == OFS_CNTHI);
    strb.alarmWr  = wrReq && (busAddr == OFS_ALARM);
    strb.guardWr  = wrReq && (busAddr == OFS_GUARD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (strb.ctrlWr) begin
      shadow.run  <= busWdata[BIT_RUN];
      shadow.alm  <= busWdata[BIT_ALM];
      shadow.wake <= busWdata[BIT_WAKE];
    end
  end

  // Control shift chain advanced by slow ticks
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           stage[i] <= '0;
        else if (slowTick) stage[i] <= shadow;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)           stage[i] <= '0;
        else if (slowTick) stage[i] <= stage[i-1];
      end
    end
  end

  assign ctrlSync = stage[LAST];

  always_comb begin
    rdMux = '0;
    case (busAddr)
      OFS_CTRL: begin
        rdMux[BIT_RUN]  = ctrlSync.run;
        rdMux[BIT_ALM]  = ctrlSync.alm;
        rdMux[BIT_WAKE] = ctrlSync.wake;
      end
      OFS_STATUS: rdMux[0] = alarmFlag;
      OFS_CNTHI:  rdMux[HI_W-1:0] = cntVal[CNT_W-1:DATA_W];
      OFS_CNTLO:  rdMux = cntVal[DATA_W-1:0];
      OFS_ALARM:  rdMux = alarmVal;
      OFS_GUARD:  rdMux = guardVal;
      default:    rdMux = '0;
    endcase
  end

  assign busRdata = rdReq ? rdMux : '0;
endmodule

// File: rtl/lp_rtc_datapath.sv
module lp_rtc_datapath
  import lp_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              slowTick,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wdata,
  input  ctrlBits_t         ctrlSync,
  output logic [CNT_W-1:0]  cntVal,
  output logic [DATA_W-1:0] alarmVal,
  output logic              alarmFlag,
  output logic [DATA_W-1:0] guardVal,
  output logic              irqOut,
  output logic              wakeOut,
  output logic              glitchOk
);
  logic [SEC_W-1:0] seconds;
  logic setCond;
  logic clrReq;

  assign seconds = cntVal[CNT_W-1:SUB_W];
  assign setCond = ctrlSync.alm && (seconds == alarmVal);
  assign clrReq  = strb.statusWr && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cntVal <= '0;
    end else if (!ctrlSync.run && strb.cntLoWr) begin
      cntVal[DATA_W-1:SUB_W] <= wdata[DATA_W-1:SUB_W];
      cntVal[SUB_W-1:0]      <= '0;
    end else if (!ctrlSync.run && strb.cntHiWr) begin
      cntVal[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
    end else if (ctrlSync.run && slowTick) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarmVal <= '0;
      guardVal <= '0;
    end else begin
      if (strb.alarmWr) alarmVal <= wdata;
      if (strb.guardWr) guardVal <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          alarmFlag <= 1'b0;
    else if (setCond) alarmFlag <= 1'b1;
    else if (clrReq)  alarmFlag <= 1'b0;
  end

  assign irqOut   = alarmFlag && ctrlSync.alm;
  assign wakeOut  = irqOut && ctrlSync.wake;
  assign glitchOk = (guardVal == GUARD_MAGIC);
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
  import lp_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slowTick,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              wakeOut,
  output logic              glitchOk
);
  regStrobe_t        strb;
  ctrlBits_t         ctrlSync;
  logic [CNT_W-1:0]  cntVal;
  logic [DATA_W-1:0] alarmVal;
  logic              alarmFlag;
  logic [DATA_W-1:0] guardVal;

  lp_rtc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .slowTick(slowTick),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .strb(strb), .ctrlSync(ctrlSync),
    .cntVal(cntVal), .alarmVal(alarmVal),
    .alarmFlag(alarmFlag), .guardVal(guardVal)
  );

  lp_rtc_datapath u_dp (
    .clk(clk), .rst(rst), .slowTick(slowTick),
    .strb(strb), .wdata(busWdata), .ctrlSync(ctrlSync),
    .cntVal(cntVal), .alarmVal(alarmVal), .alarmFlag(alarmFlag),
    .guardVal(guardVal), .irqOut(irqOut), .wakeOut(wakeOut),
    .glitchOk(glitchOk)
  );
endmodule

// File: rtl/lp_rtc_chk.sv
module lp_rtc_chk
  import lp_rtc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              slowTick,
  input regStrobe_t        strb,
  input ctrlBits_t         ctrlSync,
  input logic [CNT_W-1:0]  cntVal,
  input logic [DATA_W-1:0] alarmVal,
  input logic              alarmFlag,
  input logic              irqOut,
  input logic              wakeOut
);
  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!slowTick && !strb.cntLoWr && !strb.cntHiWr) |=> $stable(cntVal));

  // R3
  step_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (slowTick && ctrlSync.run) |=> (cntVal == $past(cntVal) + 1'b1));

  // R5
  run_blocks_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrlSync.run && !slowTick) |=> $stable(cntVal));

  // R2
  ctrl_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !slowTick |=> $stable(ctrlSync));

  // R6
  alarm_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrlSync.alm && (cntVal[CNT_W-1:SUB_W] == alarmVal)) |=> alarmFlag);

  // R8
  wake_needs_irq_chk: assert property (@(posedge clk) disable iff (rst)
    wakeOut |-> irqOut);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> alarmFlag);
endmodule

bind lp_rtc lp_rtc_chk u_chk (
  .clk(clk), .rst(rst), .slowTick(slowTick), .strb(strb),
  .ctrlSync(ctrlSync), .cntVal(cntVal), .alarmVal(alarmVal),
  .alarmFlag(alarmFlag), .irqOut(irqOut), .wakeOut(wakeOut)
);

// File: tb/lp_rtc_test.sv
module lp_rtc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slowTick = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, wakeOut, glitchOk;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  lp_rtc uut (
    .clk(clk), .rst(rst), .slowTick(slowTick), .busSel(busSel),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .wakeOut(wakeOut),
    .glitchOk(glitchOk)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 33;
  localparam vec_t VEC [NVEC] = '{
    {OP_RD, 8'h04, 32'h0000_0000, 4'd1},  // R1
    {OP_RD, 8'h18, 32'h0000_0000, 4'd1},  // R1
    {OP_RD, 8'h1C, 32'h0000_0000, 4'd1},  // R1
    {OP_RD, 8'h24, 32'h0000_0000, 4'd1},  // R1
    {OP_WR, 8'h20, 32'h0001_9ABC, 4'd4},  // R4
    {OP_RD, 8'h20, 32'h0001_8000, 4'd4},  // R4 fraction cleared
    {OP_WR, 8'h1C, 32'hFFFF_0002, 4'd4},  // R4
    {OP_RD, 8'h1C, 32'h0000_0002, 4'd4},  // R4
    {OP_WR, 8'h04, 32'h0000_0001, 4'd2},  // R2
    {OP_RD, 8'h04, 32'h0000_0000, 4'd2},  // R2 not yet landed
    {OP_TK, 8'h00, 32'h0,         4'd2},
    {OP_TK, 8'h00, 32'h0,         4'd2},
    {OP_RD, 8'h04, 32'h0000_0000, 4'd2},  // R2 after two ticks
    {OP_TK, 8'h00, 32'h0,         4'd2},
    {OP_RD, 8'h04, 32'h0000_0001, 4'd2},  // R2 after third tick
    {OP_TK, 8'h00, 32'h0,         4'd3},
    {OP_RD, 8'h20, 32'h0001_8001, 4'd3},  // R3 one step
    {OP_WR, 8'h20, 32'h0000_0000, 4'd5},  // R5
    {OP_WR, 8'h1C, 32'h0000_0000, 4'd5},  // R5
    {OP_RD, 8'h20, 32'h0001_8001, 4'd5},  // R5 ignored
    {OP_RD, 8'h1C, 32'h0000_0002, 4'd5},  // R5 ignored
    {OP_WR, 8'h30, 32'h4173_6166, 4'd9},  // R9
    {OP_RD, 8'h30, 32'h4173_6166, 4'd9},  // R9
    {OP_RD, 8'h08, 32'h0000_0000, 4'd10}, // R10
    {OP_WR, 8'h08, 32'hFFFF_FFFF, 4'd10}, // R10
    {OP_RD, 8'h08, 32'h0000_0000, 4'd10}, // R10
    {OP_WR, 8'h24, 32'hDEAD_BEEF, 4'd6},  // R6
    {OP_RD, 8'h24, 32'hDEAD_BEEF, 4'd6},  // R6
    {OP_WR, 8'h04, 32'hFFFF_FFFF, 4'd2},  // R2
    {OP_TK, 8'h00, 32'h0,         4'd2},
    {OP_TK, 8'h00, 32'h0,         4'd2},
    {OP_TK, 8'h00, 32'h0,         4'd2},
    {OP_RD, 8'h04, 32'h0000_000B, 4'd2}   // R2 only defined bits
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    check(req, $sformatf("read %h", a), busRdata, exp);
    busSel = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    slowTick = 1'b1;
    @(negedge clk);
    slowTick = 1'b0;
  endtask

  task automatic ticks3();
    tick(); tick(); tick();
  endtask

  task automatic checkPins(input int req, input logic expIrq, input logic expWake);
    @(negedge clk);
    check(req, "irqOut", {31'b0, irqOut}, {31'b0, expIrq});
    check(req, "wakeOut", {31'b0, wakeOut}, {31'b0, expWake});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 output pins after reset
    checkPins(1, 1'b0, 1'b0);
    check(1, "glitchOk", {31'b0, glitchOk}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        OP_WR:   busWrite(VEC[i].addr, VEC[i].data);
        OP_RD:   busRead(VEC[i].addr, VEC[i].data, int'(VEC[i].req));
        default: tick();
      endcase
    end

    // R9 guard pattern
    @(negedge clk);
    check(9, "glitchOk magic", {31'b0, glitchOk}, 32'h1);
    busWrite(8'h30, 32'h4173_6167);
    @(negedge clk);
    check(9, "glitchOk other", {31'b0, glitchOk}, 32'h0);

    // stop counting, load seconds = 8
    busWrite(8'h04, 32'h0);
    ticks3();
    busWrite(8'h20, 32'h0004_0000);
    busWrite(8'h1C, 32'h0);
    busRead(8'h20, 32'h0004_0000, 4);   // R4
    tick();
    busRead(8'h20, 32'h0004_0000, 3);   // R3 holds while stopped

    // R6 matching value but alarm not enabled
    busWrite(8'h24, 32'd8);
    tick();
    busRead(8'h18, 32'h0, 6);
    checkPins(8, 1'b0, 1'b0);           // R8

    // R6 enable run and alarm
    busWrite(8'h04, 32'h3);
    ticks3();
    busRead(8'h18, 32'h1, 6);
    checkPins(8, 1'b1, 1'b0);           // R8 no wake without bit 3

    // R7 write-one-to-clear
    busWrite(8'h18, 32'h0);
    busRead(8'h18, 32'h1, 7);           // zero has no effect
    busWrite(8'h18, 32'h1);
    busRead(8'h18, 32'h1, 7);           // set wins while matching
    busWrite(8'h24, 32'd100);
    busWrite(8'h18, 32'h1);
    busRead(8'h18, 32'h0, 7);
    checkPins(7, 1'b0, 1'b0);

    // R8 wakeup path
    busWrite(8'h04, 32'hB);
    ticks3();
    busRead(8'h04, 32'hB, 2);
    busWrite(8'h24, 32'd8);
    busRead(8'h18, 32'h1, 6);
    checkPins(8, 1'b1, 1'b1);

    // R8 alarm enable withdrawn: flag stays, outputs drop
    busWrite(8'h04, 32'h9);
    ticks3();
    checkPins(8, 1'b0, 1'b0);
    busRead(8'h18, 32'h1, 8);

    // R1 reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    busRead(8'h04, 32'h0, 1);
    busRead(8'h20, 32'h0, 1);
    busRead(8'h18, 32'h0, 1);
    busRead(8'h30, 32'h0, 1);
    checkPins(1, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule